// File: doc/BRIEF.md
# Low-Power Clock Mode Sequencer

This block steps a processor subsystem between a running state and three power-saving states: a light one where only the processor clock stops, a deeper one where the processor and every peripheral clock stop while the oscillator keeps running, and the deepest one where the oscillator and clock generator also shut down. Software chooses a state with a two-bit mode code and a one-cycle request strobe. The block then drives the oscillator enable, the processor clock enable and one clock enable for each peripheral group.

Interrupt requests bring the block back to the running state. The light state accepts peripheral and external-pin interrupts. The two deeper states accept only external-pin interrupts. Leaving the deepest state restarts the oscillator first. A warm-up state then holds every other clock off while a down-counter on the free-running reference clock counts out the oscillator settling time. Only after that are the clocks restored. A state code output reports where the sequencer is. A one-cycle wake pulse marks the return to the running state.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset the state code is 0 (running), `osc_en`, `cpu_clk_en` and all six `pclk_en` bits are 1, and `wake_pulse` is 0.
- R2: In the running state, a cycle with `mode_req`=1 moves the state on the next clock edge as follows: code 2'b01 goes to light sleep (state 1), 2'b10 to halt (state 2) and 2'b11 to stop (state 3). State 4 is the warm-up state. Only a request causes this entry.
- R3: A request with mode code 2'b00 leaves the block in the running state. A request made in any state other than running is ignored.
- R4: In light sleep, `cpu_clk_en`=0 and `osc_en`=1. The `pclk_en` bits are: bit0 8-bit timer, bit1 16-bit timer, bit2 serial, bit3 A/D, bit4 bus controller, bit5 watchdog. Bits 0 to 3 are 1, bit5 is 0, and bit4 follows `bus_svc_req`.
- R5: In halt, `osc_en`=1, and `cpu_clk_en` and every `pclk_en` bit are 0.
- R6: In stop, `osc_en`, `cpu_clk_en` and every `pclk_en` bit are 0.
- R7: In light sleep, any bit of `per_irq` or of `ext_irq` returns the state to running on the next edge.
- R8: In halt and stop, `per_irq` has no effect. In halt, any `ext_irq` bit returns the state to running on the next edge.
- R9: In stop, any `ext_irq` bit moves the state to warm-up (4) on the next edge. Warm-up lasts exactly STAB_CYC cycles with `osc_en`=1 and all other clocks off. The state then becomes running.
- R10: `wake_pulse` is 1 for exactly the first cycle in the running state after light sleep, halt or warm-up, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req | input | 1 | One-cycle request strobe from software |
| mode_sel | input | 2 | Requested mode code |
| per_irq | input | N_PER | Peripheral interrupt requests |
| ext_irq | input | N_EXT | External pin interrupt requests |
| bus_svc_req | input | 1 | Refresh or external bus service pending |
| osc_en | output | 1 | Oscillator and clock generator enable |
| cpu_clk_en | output | 1 | Processor clock enable |
| pclk_en | output | 6 | Peripheral group clock enables |
| state_o | output | 3 | Current state code |
| wake_pulse | output | 1 | One-cycle return-to-running marker |

## Verification
The hardest case to reach is the exact end of the warm-up wait. It needs a stop entry, an external-pin wake and then over a thousand idle cycles. The bench must also confirm the clocks stay off until the last warm-up cycle and then turn on exactly one edge later. The stimulus enters stop, shows that a peripheral interrupt there has no effect, and pulses one external pin. It then counts STAB_CYC-1 sampled cycles still in warm-up before it expects running together with the wake pulse.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_HALT  = 3'd2,
        ST_STOP  = 3'd3,
        ST_WARM  = 3'd4
    } lpm_state_e;

    localparam int PG_T8   = 0;
    localparam int PG_T16  = 1;
    localparam int PG_SER  = 2;
    localparam int PG_ADC  = 3;
    localparam int PG_BUS  = 4;
    localparam int PG_WDT  = 5;
    localparam int PG_NUM  = 6;

    typedef struct packed {
        lpm_state_e st;
        logic       wake;
    } fsm_t;
endpackage

// File: rtl/lpm_clk_map.sv
module lpm_clk_map
    import lpm_pkg::*;
(
    input  lpm_state_e         st,
    input  logic               bus_svc_req,
    output logic               osc_en,
    output logic               cpu_en,
    output logic [PG_NUM-1:0]  pg_en
);
    always_comb begin
        osc_en = 1'b1;
        cpu_en = 1'b0;
        pg_en  = '0;
        case (st)
            ST_RUN: begin
                cpu_en = 1'b1;
                pg_en  = '1;
            end
            ST_SLEEP: begin
                pg_en[PG_T8]  = 1'b1;
                pg_en[PG_T16] = 1'b1;
                pg_en[PG_SER] = 1'b1;
                pg_en[PG_ADC] = 1'b1;
                pg_en[PG_BUS] = bus_svc_req;
            end
            ST_STOP: osc_en = 1'b0;
            default: ;
        endcase
    end
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
    import lpm_pkg::*;
#(
    parameter int N_PER = 8,
    parameter int N_EXT = 4
) (
    input  lpm_state_e        st,
    input  logic [N_PER-1:0]  per_irq,
    input  logic [N_EXT-1:0]  ext_irq,
    output logic              wake_hit
);
    logic per_any;
    logic ext_any;

    assign per_any = |per_irq;
    assign ext_any = |ext_irq;

    always_comb begin
        case (st)
            ST_SLEEP:         wake_hit = per_any | ext_any;
            ST_HALT, ST_STOP: wake_hit = ext_any;
            default:          wake_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpm_stab_cnt.sv
module lpm_stab_cnt #(
    parameter int STAB_CYC = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int CW = (STAB_CYC > 1) ? $clog2(STAB_CYC) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(STAB_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
    import lpm_pkg::*;
#(
    parameter int N_PER    = 8,
    parameter int N_EXT    = 4,
    parameter int STAB_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req,
    input  logic [1:0]        mode_sel,
    input  logic [N_PER-1:0]  per_irq,
    input  logic [N_EXT-1:0]  ext_irq,
    input  logic              bus_svc_req,
    output logic              osc_en,
    output logic              cpu_clk_en,
    output logic [5:0]        pclk_en,
    output logic [2:0]        state_o,
    output logic              wake_pulse
);
    fsm_t fsm_d, fsm_q;
    logic wake_hit;
    logic stab_load;
    logic stab_zero;

    lpm_wake_qual #(.N_PER(N_PER), .N_EXT(N_EXT)) u_wq (
        .st       (fsm_q.st),
        .per_irq  (per_irq),
        .ext_irq  (ext_irq),
        .wake_hit (wake_hit)
    );

    lpm_stab_cnt #(.STAB_CYC(STAB_CYC)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (stab_load),
        .zero  (stab_zero)
    );

    lpm_clk_map u_map (
        .st          (fsm_q.st),
        .bus_svc_req (bus_svc_req),
        .osc_en      (osc_en),
        .cpu_en      (cpu_clk_en),
        .pg_en       (pclk_en)
    );

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.wake = 1'b0;
        stab_load  = 1'b0;
        case (fsm_q.st)
            ST_RUN: begin
                if (mode_req) begin
                    case (mode_sel)
                        2'b01:   fsm_d.st = ST_SLEEP;
                        2'b10:   fsm_d.st = ST_HALT;
                        2'b11:   fsm_d.st = ST_STOP;
                        default: fsm_d.st = ST_RUN;
                    endcase
                end
            end
            ST_SLEEP, ST_HALT: begin
                if (wake_hit) begin
                    fsm_d.st   = ST_RUN;
                    fsm_d.wake = 1'b1;
                end
            end
            ST_STOP: begin
                if (wake_hit) begin
                    fsm_d.st  = ST_WARM;
                    stab_load = 1'b1;
                end
            end
            ST_WARM: begin
                if (stab_zero) begin
                    fsm_d.st   = ST_RUN;
                    fsm_d.wake = 1'b1;
                end
            end
            default: fsm_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st   <= ST_RUN;
            fsm_q.wake <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o    = fsm_q.st;
    assign wake_pulse = fsm_q.wake;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
    parameter int N_PER = 8,
    parameter int N_EXT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_req,
    input logic [1:0]        mode_sel,
    input logic [N_PER-1:0]  per_irq,
    input logic [N_EXT-1:0]  ext_irq,
    input logic              osc_en,
    input logic              cpu_clk_en,
    input logic [5:0]        pclk_en,
    input logic [2:0]        state_o,
    input logic              wake_pulse
);
    // R2
    no_self_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && !mode_req) |=> state_o == 3'd0);
    // R3
    null_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && mode_req && mode_sel == 2'b00) |=> state_o == 3'd0);
    // R4
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1) |-> (!cpu_clk_en && osc_en && pclk_en[3:0] == 4'hF && !pclk_en[5]));
    // R5
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2) |-> (osc_en && !cpu_clk_en && pclk_en == 6'd0));
    // R6
    stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd3) |-> (!osc_en && !cpu_clk_en && pclk_en == 6'd0));
    // R7
    sleep_per_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && (|per_irq)) |=> state_o == 3'd0);
    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd2 && !(|ext_irq)) |=> state_o == 3'd2);
    // R9
    warm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |-> (osc_en && !cpu_clk_en && pclk_en == 6'd0));
    // R10
    wake_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (state_o == 3'd0 && $past(state_o) != 3'd0));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.N_PER(N_PER), .N_EXT(N_EXT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_req   (mode_req),
    .mode_sel   (mode_sel),
    .per_irq    (per_irq),
    .ext_irq    (ext_irq),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .pclk_en    (pclk_en),
    .state_o    (state_o),
    .wake_pulse (wake_pulse)
);

// File: tb/sim_lpm_clk_ctrl.sv
`timescale 1ns/1ps
module sim_lpm_clk_ctrl;
    localparam int N_PER = 8;
    localparam int N_EXT = 4;
    localparam int STAB  = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_req = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [N_PER-1:0] per_irq = '0;
    logic [N_EXT-1:0] ext_irq = '0;
    logic bus_svc_req = 1'b0;
    logic osc_en, cpu_clk_en, wake_pulse;
    logic [5:0] pclk_en;
    logic [2:0] state_o;

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lpm_clk_ctrl #(.N_PER(N_PER), .N_EXT(N_EXT), .STAB_CYC(STAB)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mode_sel(mode_sel),
        .per_irq(per_irq), .ext_irq(ext_irq), .bus_svc_req(bus_svc_req),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .pclk_en(pclk_en),
        .state_o(state_o), .wake_pulse(wake_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic request(input logic [1:0] code);
        mode_sel = code;
        mode_req = 1'b1;
        step();
        mode_req = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
        chk("R1 state", 32'(state_o), 32'd0);
        chk("R1 osc", 32'(osc_en), 32'd1);
        chk("R1 cpu", 32'(cpu_clk_en), 32'd1);
        chk("R1 pclk", 32'(pclk_en), 32'h3F);
        chk("R1 wake", 32'(wake_pulse), 32'd0);
    endtask

    task automatic t_null_req();
        request(2'b00);
        chk("R3 null code state", 32'(state_o), 32'd0);
        chk("R3 null code cpu", 32'(cpu_clk_en), 32'd1);
    endtask

    task automatic t_sleep();
        request(2'b01);
        chk("R2 sleep entry", 32'(state_o), 32'd1);
        chk("R4 sleep cpu", 32'(cpu_clk_en), 32'd0);
        chk("R4 sleep pclk bus idle", 32'(pclk_en), 32'h0F);
        bus_svc_req = 1'b1;
        #1;
        chk("R4 sleep pclk bus svc", 32'(pclk_en), 32'h1F);
        bus_svc_req = 1'b0;
        request(2'b10);
        chk("R3 req in sleep ignored", 32'(state_o), 32'd1);
        per_irq = 8'h20;
        step();
        per_irq = '0;
        chk("R7 per wake state", 32'(state_o), 32'd0);
        chk("R10 sleep wake pulse", 32'(wake_pulse), 32'd1);
        step();
        chk("R10 pulse one cycle", 32'(wake_pulse), 32'd0);
        request(2'b01);
        ext_irq = 4'h1;
        step();
        ext_irq = '0;
        chk("R7 ext wake sleep", 32'(state_o), 32'd0);
    endtask

    task automatic t_halt();
        step();
        request(2'b10);
        chk("R2 halt entry", 32'(state_o), 32'd2);
        chk("R5 halt osc", 32'(osc_en), 32'd1);
        chk("R5 halt clocks", 32'({cpu_clk_en, pclk_en}), 32'd0);
        per_irq = '1;
        step();
        step();
        per_irq = '0;
        chk("R8 halt per ignored", 32'(state_o), 32'd2);
        chk("R8 halt wake pulse low", 32'(wake_pulse), 32'd0);
        ext_irq = 4'h8;
        step();
        ext_irq = '0;
        chk("R8 halt ext wake", 32'(state_o), 32'd0);
        chk("R10 halt wake pulse", 32'(wake_pulse), 32'd1);
    endtask

    task automatic t_stop();
        step();
        request(2'b11);
        chk("R2 stop entry", 32'(state_o), 32'd3);
        chk("R6 stop gates", 32'({osc_en, cpu_clk_en, pclk_en}), 32'd0);
        per_irq = 8'h01;
        step();
        per_irq = '0;
        chk("R8 stop per ignored", 32'(state_o), 32'd3);
        ext_irq = 4'h2;
        step();
        ext_irq = '0;
        chk("R9 warm entry", 32'(state_o), 32'd4);
        chk("R9 warm osc", 32'(osc_en), 32'd1);
        chk("R9 warm clocks", 32'({cpu_clk_en, pclk_en}), 32'd0);
        for (int i = 0; i < STAB - 1; i++) step();
        chk("R9 warm last cycle", 32'(state_o), 32'd4);
        chk("R9 warm last cpu off", 32'(cpu_clk_en), 32'd0);
        step();
        chk("R9 warm exit", 32'(state_o), 32'd0);
        chk("R9 clocks restored", 32'({osc_en, cpu_clk_en, pclk_en}), 32'hFF);
        chk("R10 stop wake pulse", 32'(wake_pulse), 32'd1);
        step();
        chk("R10 pulse cleared", 32'(wake_pulse), 32'd0);
    endtask

    initial begin
        t_reset();
        t_null_req();
        t_sleep();
        t_halt();
        t_stop();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vecs++;
            errs++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule